// File: doc/BRIEF.md
# Adaptive-Threshold Pulse-Width Infrared Frame Decoder

The block takes the output of an infrared receiver module, which idles high and is pulled low while carrier is present, and turns each pulse-width frame of up to twelve bits into a data word. A frame opens with a long low leader. Each bit is then a short high phase, the mark, followed by a low phase, the space. The space is short for a zero and long for a one. The decoder counts each phase in ticks of a prescaled clock. It stores every (mark, space) pair and keeps the smallest and largest bit period seen in the frame, where the bit period is mark plus space.

Once the frame ends, the decoder places a threshold halfway between the extremes and sorts every stored bit against it. The result does not depend on the absolute tick rate: a transmitter whose timing drifts, or a prescaler that is off by some percent, still decodes, provided both bit lengths appear in the frame. The decoded word, the bit count and the threshold are registered together with a one-clock completion strobe. The raw pairs stay readable through an index port until the next frame overwrites them.

The controller is a state machine with seven states:
- `ST_IDLE`: clears the frame variables and leaves when the synchronized input is low.
- `ST_LEADER`: leaves on the rising edge that ends the leader.
- `ST_MARK`: leaves on a falling edge to `ST_SPACE`, or on counter saturation to `ST_THRESH`.
- `ST_SPACE`: leaves on a rising edge, back to `ST_MARK` or, after the twelfth bit, to `ST_THRESH`.
- `ST_THRESH`: computes the threshold and goes to `ST_CLASSIFY`, or to `ST_DONE` when the frame holds no bits.
- `ST_CLASSIFY`: steps one stored bit per clock and goes to `ST_DONE` after the last one.
- `ST_DONE`: publishes the results and returns to `ST_IDLE`.

Top module: `ir_frame_decoder`

## Requirements
- R1: After reset, `word_o`, `bit_count_o`, `threshold_o`, `frame_done_o`, `rd_mark_o` and `rd_space_o` are all zero.
- R2: A frame begins only after the synchronized input has been low and then returns high. Mark counting starts at that rising edge, and a high phase of D ticks is stored as D.
- R3: For bit i, the mark ticks and the space ticks are stored separately and read on `rd_mark_o`/`rd_space_o` when `rd_idx_i` equals i. Any index of 12 or more reads zero.
- R4: The phase counter saturates at 255 ticks. A space of 255 ticks or longer is stored as 255, and the 9-bit period sum never wraps.
- R5: The minimum bit period starts at 255 and the maximum at 0. They update after every bit (minimum when the sum is smaller, maximum when the sum is greater or equal). The threshold equals min + ((max − min) >> 1), truncated.
- R6: A bit whose period is greater than or equal to the threshold decodes as 1, otherwise as 0. A frame whose bits all share one period therefore decodes as all ones.
- R7: The first bit received lands in `word_o` bit 0 and each later bit one position higher. All bits at or above `bit_count_o` are zero.
- R8: At most 12 bits are collected. The frame closes directly after the twelfth space, with `bit_count_o` = 12.
- R9: A mark that reaches 255 ticks without a falling edge closes the frame with the bits collected so far. A frame closed this way before any bit yields count 0, word 0 and threshold 0.
- R10: `frame_done_o` is high for exactly one clock per frame. Word, count and threshold change only with it and hold until the next frame. The decoder then waits for the next leader.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_rx_i | input | 1 | Receiver output, low while carrier present, asynchronous |
| word_o | output | 32 | Decoded frame, first bit in bit 0 |
| bit_count_o | output | 4 | Number of bits in the last frame |
| threshold_o | output | 9 | Midpoint threshold of the last frame, in ticks |
| frame_done_o | output | 1 | One-clock strobe when the results above update |
| rd_idx_i | input | 4 | Index of a stored period pair |
| rd_mark_o | output | 8 | Mark tick count of the indexed bit |
| rd_space_o | output | 8 | Space tick count of the indexed bit |

## Verification
The bound checker watches on every cycle the properties that concern only the result ports:
- the strobe lasts one clock;
- the count never exceeds twelve;
- no word bit is set at or above the count;
- an empty frame reports zero word and threshold;
- the results stay frozen between strobes.

Whether tick counts, saturation, minimum/maximum tracking, the truncated midpoint and the greater-or-equal rule give the right word can only be shown by the bench's frames. The bench drives frames with known phase lengths: mixed lengths, uniform lengths, a bit exactly on the threshold, an over-long space, an empty frame and a full twelve-bit frame. It compares the results and every stored pair against values computed from the requirements.

// File: rtl/ifd_pkg.sv
package ifd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEADER,
        ST_MARK,
        ST_SPACE,
        ST_THRESH,
        ST_CLASSIFY,
        ST_DONE
    } ifd_state_e;

endpackage

// File: rtl/ifd_sync.sv
// Multi-flop synchronizer for an idle-high input, with edge pulses.
module ifd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], din};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign level = chain_q[STAGES-1];
    assign rise  = level & ~prev_q;
    assign fall  = ~level & prev_q;

endmodule

// File: rtl/ifd_prescale.sv
// Tick enable: one pulse every DIV clocks (always on when DIV is 1).
module ifd_prescale #(
    parameter int DIV = 800
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    generate
        if (DIV <= 1) begin : g_passthru
            assign tick = 1'b1;
        end else begin : g_divider
            localparam int PW = $clog2(DIV);
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);
            logic [PW-1:0] div_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    div_q <= '0;
                end else if (div_q == LAST) begin
                    div_q <= '0;
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end

            assign tick = (div_q == LAST);
        end
    endgenerate

endmodule

// File: rtl/ifd_pair_store.sv
// Storage for per-bit (mark, space) tick counts, with two read ports:
// one returns the summed period, the other the raw pair.
module ifd_pair_store #(
    parameter int DEPTH = 12,
    parameter int CW    = 8,
    parameter int IW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [CW-1:0] wr_mark,
    input  logic [CW-1:0] wr_space,
    input  logic [IW-1:0] sum_idx,
    output logic [CW:0]   sum_out,
    input  logic [IW-1:0] raw_idx,
    output logic [CW-1:0] raw_mark,
    output logic [CW-1:0] raw_space
);

    localparam logic [IW-1:0] DEPTH_L = IW'(DEPTH);

    logic [CW-1:0] mark_mem  [DEPTH];
    logic [CW-1:0] space_mem [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_entry
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mark_mem[g]  <= '0;
                    space_mem[g] <= '0;
                end else if (wr_en && (wr_idx == IW'(g))) begin
                    mark_mem[g]  <= wr_mark;
                    space_mem[g] <= wr_space;
                end
            end
        end
    endgenerate

    always_comb begin
        sum_out = '0;
        if (sum_idx < DEPTH_L) begin
            sum_out = {1'b0, mark_mem[sum_idx]} + {1'b0, space_mem[sum_idx]};
        end
    end

    always_comb begin
        raw_mark  = '0;
        raw_space = '0;
        if (raw_idx < DEPTH_L) begin
            raw_mark  = mark_mem[raw_idx];
            raw_space = space_mem[raw_idx];
        end
    end

endmodule

// File: rtl/ir_frame_decoder.sv
module ir_frame_decoder
    import ifd_pkg::*;
#(
    parameter int TICK_DIV = 800,
    parameter int CNT_W    = 8,
    parameter int MAX_BITS = 12,
    parameter int WORD_W   = 32,
    localparam int IDX_W   = $clog2(MAX_BITS + 1),
    localparam int SUM_W   = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ir_rx_i,
    output logic [WORD_W-1:0] word_o,
    output logic [IDX_W-1:0]  bit_count_o,
    output logic [SUM_W-1:0]  threshold_o,
    output logic              frame_done_o,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [CNT_W-1:0]  rd_mark_o,
    output logic [CNT_W-1:0]  rd_space_o
);

    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [SUM_W-1:0] MIN_INIT = SUM_W'(CNT_MAX);
    localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(MAX_BITS - 1);

    ifd_state_e state_q, state_d;

    logic             ir_lvl, ir_rise, ir_fall, tick;
    logic [CNT_W-1:0] cnt_q, cnt_inc, mark_q;
    logic [IDX_W-1:0] nbits_q, cls_idx_q;
    logic [SUM_W-1:0] min_q, max_q, thr_q, sum_now, stored_sum;
    logic [WORD_W-1:0] acc_q;
    logic             store_en;

    ifd_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ir_rx_i),
        .level (ir_lvl),
        .rise  (ir_rise),
        .fall  (ir_fall)
    );

    ifd_prescale #(.DIV(TICK_DIV)) u_prescale (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    ifd_pair_store #(.DEPTH(MAX_BITS), .CW(CNT_W), .IW(IDX_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (store_en),
        .wr_idx    (nbits_q),
        .wr_mark   (mark_q),
        .wr_space  (cnt_inc),
        .sum_idx   (cls_idx_q),
        .sum_out   (stored_sum),
        .raw_idx   (rd_idx_i),
        .raw_mark  (rd_mark_o),
        .raw_space (rd_space_o)
    );

    // Saturating phase count including the current cycle's tick.
    assign cnt_inc  = (tick && (cnt_q != CNT_MAX)) ? cnt_q + 1'b1 : cnt_q;
    assign sum_now  = {1'b0, mark_q} + {1'b0, cnt_inc};
    assign store_en = (state_q == ST_SPACE) && ir_rise;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!ir_lvl) state_d = ST_LEADER;
            end
            ST_LEADER: begin
                if (ir_rise) state_d = ST_MARK;
            end
            ST_MARK: begin
                if (ir_fall) begin
                    state_d = ST_SPACE;
                end else if (cnt_inc == CNT_MAX) begin
                    state_d = ST_THRESH;
                end
            end
            ST_SPACE: begin
                if (ir_rise) begin
                    state_d = (nbits_q == LAST_BIT) ? ST_THRESH : ST_MARK;
                end
            end
            ST_THRESH: begin
                state_d = (nbits_q == '0) ? ST_DONE : ST_CLASSIFY;
            end
            ST_CLASSIFY: begin
                if (cls_idx_q == nbits_q - 1'b1) state_d = ST_DONE;
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q        <= '0;
            mark_q       <= '0;
            nbits_q      <= '0;
            min_q        <= MIN_INIT;
            max_q        <= '0;
            thr_q        <= '0;
            acc_q        <= '0;
            cls_idx_q    <= '0;
            word_o       <= '0;
            bit_count_o  <= '0;
            threshold_o  <= '0;
            frame_done_o <= 1'b0;
        end else begin
            frame_done_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q   <= '0;
                    nbits_q <= '0;
                    min_q   <= MIN_INIT;
                    max_q   <= '0;
                    acc_q   <= '0;
                end
                ST_LEADER: begin
                    cnt_q <= '0;
                end
                ST_MARK: begin
                    if (ir_fall) begin
                        mark_q <= cnt_inc;
                        cnt_q  <= '0;
                    end else begin
                        cnt_q <= cnt_inc;
                    end
                end
                ST_SPACE: begin
                    if (ir_rise) begin
                        cnt_q   <= '0;
                        nbits_q <= nbits_q + 1'b1;
                        if (sum_now >= max_q) max_q <= sum_now;
                        if (sum_now < min_q)  min_q <= sum_now;
                    end else begin
                        cnt_q <= cnt_inc;
                    end
                end
                ST_THRESH: begin
                    cls_idx_q <= '0;
                    if (nbits_q == '0) begin
                        thr_q <= '0;
                    end else begin
                        thr_q <= min_q + ((max_q - min_q) >> 1);
                    end
                end
                ST_CLASSIFY: begin
                    if (stored_sum >= thr_q) acc_q[cls_idx_q] <= 1'b1;
                    cls_idx_q <= cls_idx_q + 1'b1;
                end
                ST_DONE: begin
                    word_o       <= acc_q;
                    bit_count_o  <= nbits_q;
                    threshold_o  <= thr_q;
                    frame_done_o <= 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ifd_checker.sv
module ifd_checker #(
    parameter int WORD_W   = 32,
    parameter int IDX_W    = 4,
    parameter int SUM_W    = 9,
    parameter int MAX_BITS = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] word_o,
    input logic [IDX_W-1:0]  bit_count_o,
    input logic [SUM_W-1:0]  threshold_o,
    input logic              frame_done_o
);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |=> !frame_done_o);

    assert_results_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done_o |-> ($stable(word_o) && $stable(bit_count_o) && $stable(threshold_o)));

    assert_count_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bit_count_o <= IDX_W'(MAX_BITS));

    assert_word_upper_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |-> ((word_o >> bit_count_o) == '0));

    assert_empty_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done_o && (bit_count_o == '0)) |-> ((word_o == '0) && (threshold_o == '0)));

endmodule

bind ir_frame_decoder ifd_checker #(
    .WORD_W   (WORD_W),
    .IDX_W    (IDX_W),
    .SUM_W    (SUM_W),
    .MAX_BITS (MAX_BITS)
) u_ifd_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .word_o       (word_o),
    .bit_count_o  (bit_count_o),
    .threshold_o  (threshold_o),
    .frame_done_o (frame_done_o)
);

// File: tb/test_ir_frame_decoder.sv
module test_ir_frame_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int MARK_T     = 25;
    localparam int ZERO_T     = 50;
    localparam int ONE_T      = 87;

    typedef struct packed {
        logic [31:0]      word;
        logic [3:0]       n;
        logic [8:0]       thr;
        logic [11:0][7:0] mk;
        logic [11:0][7:0] sp;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ir_rx = 1'b1;
    logic [3:0]  rd_idx = '0;
    logic [31:0] word;
    logic [3:0]  bit_count;
    logic [8:0]  threshold;
    logic        frame_done;
    logic [7:0]  rd_mark, rd_space;

    int checks = 0;
    int fails = 0;
    int frames_sent = 0;
    int frames_seen = 0;
    exp_t exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    ir_frame_decoder #(.TICK_DIV(1)) i_ir_frame_decoder (
        .clk          (clk),
        .rst_n        (rst_n),
        .ir_rx_i      (ir_rx),
        .word_o       (word),
        .bit_count_o  (bit_count),
        .threshold_o  (threshold),
        .frame_done_o (frame_done),
        .rd_idx_i     (rd_idx),
        .rd_mark_o    (rd_mark),
        .rd_space_o   (rd_space)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic hold_level(input logic lvl, input int cycles);
        ir_rx = lvl;
        repeat (cycles) @(negedge clk);
    endtask

    // Driver: sends leader, n bits (mark MARK_T, given spaces), then a long high.
    task automatic send_frame(input int n, input int spaces[12]);
        exp_t e;
        int   mn, mx, s, sums[12];
        e = '0;
        mn = 255;
        mx = 0;
        for (int i = 0; i < n; i++) begin
            e.mk[i] = 8'(MARK_T);
            e.sp[i] = (spaces[i] > 255) ? 8'd255 : 8'(spaces[i]);
            s = MARK_T + int'(e.sp[i]);
            sums[i] = s;
            if (s >= mx) mx = s;
            if (s < mn)  mn = s;
        end
        e.n = 4'(n);
        e.thr = (n == 0) ? 9'd0 : 9'(mn + ((mx - mn) / 2));
        for (int i = 0; i < n; i++) begin
            if (sums[i] >= int'(e.thr)) e.word[i] = 1'b1;
        end
        exp_q.push_back(e);
        frames_sent++;
        hold_level(1'b0, 160);
        for (int i = 0; i < n; i++) begin
            hold_level(1'b1, MARK_T);
            hold_level(1'b0, spaces[i]);
        end
        hold_level(1'b1, 400);
        wait (frames_seen == frames_sent);
        @(negedge clk);
    endtask

    // Monitor: pops expectations on each strobe and compares.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (frame_done) begin
                if (exp_q.size() == 0) begin
                    chk("R10 unexpected strobe", 32'd1, 32'd0);
                end else begin
                    e = exp_q.pop_front();
                    chk("R7 decoded word", word, e.word);
                    chk("R8 bit count", 32'(bit_count), 32'(e.n));
                    chk("R5 threshold", 32'(threshold), 32'(e.thr));
                    @(negedge clk);
                    chk("R10 strobe one clock", 32'(frame_done), 32'd0);
                    for (int i = 0; i < 12; i++) begin
                        if (i < int'(e.n)) begin
                            rd_idx = 4'(i);
                            #1;
                            chk("R3 stored mark", 32'(rd_mark), 32'(e.mk[i]));
                            chk("R4 stored space", 32'(rd_space), 32'(e.sp[i]));
                        end
                    end
                    rd_idx = 4'd13;
                    #1;
                    chk("R3 out-of-range index", {16'd0, rd_mark, rd_space}, 32'd0);
                    repeat (5) @(negedge clk);
                    chk("R10 word held", word, e.word);
                end
                frames_seen++;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int sp[12];
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset word", word, 32'd0);
        chk("R1 reset count", 32'(bit_count), 32'd0);
        chk("R1 reset threshold", 32'(threshold), 32'd0);
        chk("R1 reset strobe", 32'(frame_done), 32'd0);
        chk("R1 reset pair", {16'd0, rd_mark, rd_space}, 32'd0);
        repeat (20) @(negedge clk);
        chk("R2 no frame while idle high", 32'(frame_done), 32'd0);

        // Mixed frame 1,0,1,1,0,0,1,0, ends by mark timeout (R2, R6, R9)
        sp = '{ONE_T, ZERO_T, ONE_T, ONE_T, ZERO_T, ZERO_T, ONE_T, ZERO_T, 0, 0, 0, 0};
        send_frame(8, sp);

        // Full 12-bit frame (R8)
        sp = '{ZERO_T, ONE_T, ONE_T, ZERO_T, ONE_T, ZERO_T, ZERO_T, ONE_T, ONE_T, ONE_T, ZERO_T, ONE_T};
        send_frame(12, sp);

        // Uniform zeros decode as all ones (R6)
        sp = '{ZERO_T, ZERO_T, ZERO_T, ZERO_T, ZERO_T, 0, 0, 0, 0, 0, 0, 0};
        send_frame(5, sp);

        // Sums 75,112,93,92 with threshold 93: equal is one (R6)
        sp = '{ZERO_T, ONE_T, 68, 67, 0, 0, 0, 0, 0, 0, 0, 0};
        send_frame(4, sp);

        // Space saturates at 255 (R4)
        sp = '{ZERO_T, 300, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
        send_frame(2, sp);

        // Single bit above 255 keeps minimum at its start value (R5)
        sp = '{240, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
        send_frame(1, sp);

        // Empty frame closed by mark timeout (R9)
        sp = '{default: 0};
        send_frame(0, sp);

        chk("R10 all frames seen", 32'(frames_seen), 32'(frames_sent));
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule